// File: doc/BRIEF.md
# Four-Channel Pulse Generator with Cycle-End Reload

The block produces four independent pulse-width modulated outputs from one clock. Each channel is set by two 32-bit tick counts written over a simple memory-mapped write port: a high-time count and a cycle-length count, both measured in clock periods. Every cycle starts with the high phase. The output stays high for the high-time count and then low for the rest of the cycle.

Writes land in per-channel shadow storage. A running channel picks up the new counts only when its current cycle ends, so a waveform is never cut short or stretched by a write in mid-cycle. A channel whose cycle length is zero is stopped: it holds its output high, and it takes new counts on the next clock. Reads return the shadow contents, which are the values last written.

Top module: `quad_pwm_gen`

## Requirements
- R1: Channel c (0..3) has its high-time register at byte address c*8 and its cycle-length register at c*8+4. Address bits [1:0] are ignored, and the channels share nothing else.
- R2: After reset, all eight registers read zero and all four outputs are high.
- R3: With cycle length L > 0 and high-time H < L, the output is high for H clocks and then low for L-H clocks, repeating with period L.
- R4: When H >= L > 0, the output stays high for every clock.
- R5: When the cycle length is zero, whatever the high-time, the channel is stopped and its output is high.
- R6: A write to a running channel leaves the current cycle unchanged. The new high-time and cycle length apply from the first cycle that starts after the write.
- R7: A stopped channel loads its counts on the first rising edge after the edge that captured the write. From the following sample, its output shows the first clock of a new cycle, which is the high phase.
- R8: The read data is combinational from the address and returns the value last written to that register. This holds on the cycle right after the write.
- R9: Byte addresses 0x20 to 0x3F read as zero, and writes to them change no register and no output.
- R10: Configuring one channel does not change the outputs of the other channels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; also the tick for all counts |
| rstN | input | 1 | Active-low synchronous reset |
| busWrEn | input | 1 | Write strobe for the current address |
| busAddr | input | 6 | Byte address |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for busAddr (combinational) |
| pwmOut | output | 4 | One modulated output per channel |

## Verification
The assertions check on every cycle that a stopped channel drives high, that the first cycle after reset has all outputs high, that each write strobe decodes to exactly one register at the right address, that out-of-range reads return zero, and that a written value reads back on the next cycle. Only the bench scenarios can show the waveform shape: the high and low run lengths for each count pair, the saturation when the high-time is at least the cycle length, the one-clock start from the stopped state, and the point at which a write during a running cycle takes effect. The bench sweeps all small count pairs on every channel and compares each sample with an arithmetic model.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int CH_N  = 4;
  localparam int CNT_W = 32;
  localparam int CH_W  = $clog2(CH_N);

  typedef struct packed {
    logic [CH_N-1:0]  ldHigh;
    logic [CH_N-1:0]  ldLen;
    logic [CNT_W-1:0] wdata;
  } regStrobe_t;
endpackage

// File: rtl/pwm_reg_ctrl.sv
module pwm_reg_ctrl #(
  parameter int ADDR_W = 6
) (
  input  logic                     busWrEn,
  input  logic [ADDR_W-1:0]        busAddr,
  input  logic [pwm_pkg::CNT_W-1:0] busWrData,
  input  logic [pwm_pkg::CNT_W-1:0] shHigh [pwm_pkg::CH_N],
  input  logic [pwm_pkg::CNT_W-1:0] shLen  [pwm_pkg::CH_N],
  output pwm_pkg::regStrobe_t      strb,
  output logic [pwm_pkg::CNT_W-1:0] busRdData
);
  import pwm_pkg::*;

  localparam int IDX_W = ADDR_W - 2;
  localparam int REG_N = 2 * CH_N;

  logic [IDX_W-1:0] wordIdx;
  logic [CH_W-1:0]  chanSel;
  logic             isLen;
  logic             inRange;
  logic             unusedAddrLo;

  assign wordIdx      = busAddr[ADDR_W-1:2];
  assign chanSel      = wordIdx[CH_W:1];
  assign isLen        = wordIdx[0];
  assign inRange      = (wordIdx < IDX_W'(REG_N));
  assign unusedAddrLo = ^busAddr[1:0];

  assign strb.wdata = busWrData;

  for (genvar c = 0; c < CH_N; c++) begin : g_dec
    assign strb.ldHigh[c] = busWrEn && inRange && (chanSel == CH_W'(c)) && !isLen;
    assign strb.ldLen[c]  = busWrEn && inRange && (chanSel == CH_W'(c)) &&  isLen;
  end

  always_comb begin
    busRdData = '0;
    if (inRange) begin
      busRdData = isLen ? shLen[chanSel] : shHigh[chanSel];
    end
  end
endmodule

// File: rtl/pwm_chan_dp.sv
module pwm_chan_dp #(
  parameter int CH_IDX = 0
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  pwm_pkg::regStrobe_t       strb,
  output logic [pwm_pkg::CNT_W-1:0] shHigh,
  output logic [pwm_pkg::CNT_W-1:0] shLen,
  output logic                      idle,
  output logic                      pwmOut
);
  import pwm_pkg::*;

  logic [CNT_W-1:0] actHigh, actLen, cnt;
  logic [CNT_W-1:0] nHigh, nLen, nCnt;
  logic             wrap, reload, nOut, outQ;

  // shadow copies, written by the bus
  always_ff @(posedge clk) begin
    if (!rstN) begin
      shHigh <= '0;
      shLen  <= '0;
    end else begin
      if (strb.ldHigh[CH_IDX]) shHigh <= strb.wdata;
      if (strb.ldLen[CH_IDX])  shLen  <= strb.wdata;
    end
  end

  always_comb begin
    idle   = (actLen == '0);
    wrap   = !idle && (cnt == actLen - CNT_W'(1));
    reload = idle || wrap;
    nHigh  = reload ? shHigh : actHigh;
    nLen   = reload ? shLen  : actLen;
    nCnt   = reload ? '0     : cnt + CNT_W'(1);
    nOut   = (nLen == '0) || (nCnt < nHigh);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      actHigh <= '0;
      actLen  <= '0;
      cnt     <= '0;
      outQ    <= 1'b1;
    end else begin
      actHigh <= nHigh;
      actLen  <= nLen;
      cnt     <= nCnt;
      outQ    <= nOut;
    end
  end

  assign pwmOut = outQ;
endmodule

// File: rtl/quad_pwm_gen.sv
module quad_pwm_gen #(
  parameter int ADDR_W = 6
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      busWrEn,
  input  logic [ADDR_W-1:0]         busAddr,
  input  logic [pwm_pkg::CNT_W-1:0] busWrData,
  output logic [pwm_pkg::CNT_W-1:0] busRdData,
  output logic [pwm_pkg::CH_N-1:0]  pwmOut
);
  import pwm_pkg::*;

  regStrobe_t       strb;
  logic [CNT_W-1:0] shHigh [CH_N];
  logic [CNT_W-1:0] shLen  [CH_N];
  logic [CH_N-1:0]  chanIdle;

  pwm_reg_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .busWrEn  (busWrEn),
    .busAddr  (busAddr),
    .busWrData(busWrData),
    .shHigh   (shHigh),
    .shLen    (shLen),
    .strb     (strb),
    .busRdData(busRdData)
  );

  for (genvar c = 0; c < CH_N; c++) begin : g_ch
    pwm_chan_dp #(.CH_IDX(c)) dp_i (
      .clk   (clk),
      .rstN  (rstN),
      .strb  (strb),
      .shHigh(shHigh[c]),
      .shLen (shLen[c]),
      .idle  (chanIdle[c]),
      .pwmOut(pwmOut[c])
    );
  end
endmodule

// File: rtl/quad_pwm_gen_chk.sv
module quad_pwm_gen_chk #(
  parameter int ADDR_W = 6
) (
  input logic                      clk,
  input logic                      rstN,
  input logic                      busWrEn,
  input logic [ADDR_W-1:0]         busAddr,
  input logic [pwm_pkg::CNT_W-1:0] busWrData,
  input logic [pwm_pkg::CNT_W-1:0] busRdData,
  input logic [pwm_pkg::CH_N-1:0]  pwmOut,
  input logic [pwm_pkg::CH_N-1:0]  chanIdle,
  input pwm_pkg::regStrobe_t       strb
);
  import pwm_pkg::*;
  localparam int IDX_W = ADDR_W - 2;

  logic inRange;
  assign inRange = (busAddr[ADDR_W-1:2] < IDX_W'(2 * CH_N));

  assert_reset_high_R2: assert property (@(posedge clk) disable iff (!rstN)
    $past(!rstN) |-> (pwmOut == '1));

  assert_oob_read_zero_R9: assert property (@(posedge clk) disable iff (!rstN)
    !inRange |-> (busRdData == '0));

  assert_readback_R8: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(busWrEn) && $past(inRange) && busAddr == $past(busAddr))
      |-> (busRdData == $past(busWrData)));

  assert_single_strobe_R1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.ldHigh, strb.ldLen}));

  for (genvar c = 0; c < CH_N; c++) begin : g_a
    assert_idle_high_R5: assert property (@(posedge clk) disable iff (!rstN)
      chanIdle[c] |-> pwmOut[c]);
    assert_high_decode_R1: assert property (@(posedge clk) disable iff (!rstN)
      strb.ldHigh[c] |-> (busAddr[ADDR_W-1:2] == IDX_W'(2 * c)));
    assert_len_decode_R1: assert property (@(posedge clk) disable iff (!rstN)
      strb.ldLen[c] |-> (busAddr[ADDR_W-1:2] == IDX_W'(2 * c + 1)));
  end
endmodule

bind quad_pwm_gen quad_pwm_gen_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .busWrEn  (busWrEn),
  .busAddr  (busAddr),
  .busWrData(busWrData),
  .busRdData(busRdData),
  .pwmOut   (pwmOut),
  .chanIdle (chanIdle),
  .strb     (strb)
);

// File: tb/quad_pwm_gen_tb_top.sv
module quad_pwm_gen_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrEn = 1'b0;
  logic [5:0]  busAddr = '0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic [3:0]  pwmOut;

  int nChecks = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  quad_pwm_gen dut_i (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .pwmOut(pwmOut)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic busWrite(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a;
    #1 d = busRdData;
  endtask

  function automatic logic model(input int len, input int hi, input int k);
    if (len == 0) return 1'b1;
    return (k % len) < hi;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    int k;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R2: reset state
    check("R2 outputs", 32'(pwmOut), 32'hF);
    for (int i = 0; i < 8; i++) begin
      busRead(6'(i * 4), rd);
      check("R2 regs", rd, 32'h0);
    end

    // R9: out-of-range write ignored
    busWrite(6'h28, 32'h3);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check("R9 outputs", 32'(pwmOut), 32'hF);
    end
    for (int i = 0; i < 8; i++) begin
      busRead(6'(i * 4), rd);
      check("R9 regs", rd, 32'h0);
    end

    // R3 R4 R5 R7 R10: sweep of small count pairs on every channel
    for (int c = 0; c < 4; c++) begin
      for (int len = 0; len <= 5; len++) begin
        for (int hi = 0; hi <= 6; hi++) begin
          busWrite(6'(c * 8), 32'(hi));
          busWrite(6'(c * 8 + 4), 32'(len));
          for (int s = 0; s < ((len == 0) ? 4 : 2 * len + 2); s++) begin
            @(negedge clk);
            if (s == 0)
              check("R7 first sample", 32'(pwmOut[c]), 32'(model(len, hi, s)));
            else if (len == 0)
              check("R5 stopped", 32'(pwmOut[c]), 32'(model(len, hi, s)));
            else if (hi >= len)
              check("R4 saturated", 32'(pwmOut[c]), 32'(model(len, hi, s)));
            else
              check("R3 waveform", 32'(pwmOut[c]), 32'(model(len, hi, s)));
            check("R10 others", 32'(pwmOut | (4'b1 << c)), 32'hF);
          end
          busWrite(6'(c * 8), 32'h0);
          busWrite(6'(c * 8 + 4), 32'h0);
          repeat (8) @(negedge clk);
          check("R5 stop", 32'(pwmOut), 32'hF);
        end
      end
    end

    // R6: high-time change in mid-cycle, then length change
    busWrite(6'h10, 32'd1);
    busWrite(6'h14, 32'd4);
    @(negedge clk);
    k = 0;
    check("R6 start", 32'(pwmOut[2]), 32'(model(4, 1, k)));
    busWrite(6'h10, 32'd3);
    k = 2;
    for (; k <= 11; k++) begin
      if (k > 2) @(negedge clk);
      check("R6 high-time", 32'(pwmOut[2]), 32'((k < 4) ? model(4, 1, k) : model(4, 3, k)));
    end
    busWrite(6'h14, 32'd6);
    k = 13;
    for (; k <= 27; k++) begin
      if (k > 13) @(negedge clk);
      check("R6 length", 32'(pwmOut[2]), 32'((k < 16) ? model(4, 3, k) : model(6, 3, k - 16)));
    end
    busWrite(6'h10, 32'h0);
    busWrite(6'h14, 32'h0);
    repeat (10) @(negedge clk);
    check("R5 stop after R6", 32'(pwmOut), 32'hF);

    // R8 R1: readback of every register, including an unaligned address
    for (int c = 0; c < 4; c++) begin
      busWrite(6'(c * 8), 32'hA5000000 | 32'(c));
      busRead(6'(c * 8), rd);
      check("R8 next-cycle readback", rd, 32'hA5000000 | 32'(c));
      busWrite(6'(c * 8 + 4), 32'hFFFF0000 + 32'(c * 16));
    end
    for (int c = 0; c < 4; c++) begin
      busRead(6'(c * 8), rd);
      check("R1 high-time addr", rd, 32'hA5000000 | 32'(c));
      busRead(6'(c * 8 + 4), rd);
      check("R1 length addr", rd, 32'hFFFF0000 + 32'(c * 16));
    end
    busRead(6'h0D, rd);
    check("R1 low bits ignored", rd, 32'hFFFF0010);

    // R9: out-of-range reads and writes
    busWrite(6'h20, 32'h12345678);
    busWrite(6'h3C, 32'h87654321);
    busRead(6'h20, rd);
    check("R9 read 0x20", rd, 32'h0);
    busRead(6'h3C, rd);
    check("R9 read 0x3C", rd, 32'h0);
    for (int c = 0; c < 4; c++) begin
      busRead(6'(c * 8), rd);
      check("R9 regs kept", rd, 32'hA5000000 | 32'(c));
    end

    // R2: reset again from a running state
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    check("R2 outputs after reset", 32'(pwmOut), 32'hF);
    for (int i = 0; i < 8; i++) begin
      busRead(6'(i * 4), rd);
      check("R2 regs after reset", rd, 32'h0);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end
endmodule